// File: doc/BRIEF.md
# Priority-Resolved Multifunction Register

This block is an N-bit register whose next value is chosen by four independent control lines: a synchronous clear, a synchronous set, a parallel load and a shift toward the most significant bit. A serial input bit supplies the new least significant bit during a shift. Any combination of the four controls may be asserted in the same cycle. A fixed priority resolves the conflict: clear, then set, then load, then shift. When no control is asserted, the register keeps its contents.

Internally, a small encoder turns the four lines into a 3-bit select. One 8-input selector per bit uses that select to pick the bit's next value. The three select codes that the encoder never produces steer every bit back to its present value. The register contents drive the output directly, with no logic after the flip-flops. Reset is synchronous and active low, and it brings the register to all zeros.

Top module: `prio_mfreg`

## Requirements
- R1: While `rst_n` is low at a rising edge, the register becomes all zeros after that edge, whatever the controls are.
- R2: With reset released, `clr_i` high at a rising edge makes the register all zeros, regardless of `set_i`, `load_i` and `shift_i`.
- R3: With `clr_i` low, `set_i` high makes every bit 1 at the edge, regardless of `load_i` and `shift_i`.
- R4: With `clr_i` and `set_i` low, `load_i` high copies `din_i` into the register at the edge, regardless of `shift_i`.
- R5: With `clr_i`, `set_i` and `load_i` low, `shift_i` high makes bit i take the old bit i-1 for i ≥ 1, and bit 0 take `shift_in_i`. The old most significant bit is discarded.
- R6: With reset released and all four controls low, the register keeps its value across the edge, and `din_i` and `shift_in_i` have no effect.
- R7: `q_o` changes only at a rising edge. A control or data change between edges leaves `q_o` unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| clr_i | input | 1 | Synchronous clear to all zeros (highest priority) |
| set_i | input | 1 | Synchronous set to all ones |
| load_i | input | 1 | Parallel load of `din_i` |
| shift_i | input | 1 | Shift toward the MSB (lowest priority) |
| shift_in_i | input | 1 | Serial bit entering bit 0 on a shift |
| din_i | input | W | Parallel load data |
| q_o | output | W | Register contents |

## Verification
Every operation's result is due on the rising edge that follows the stimulus: one register stage, with nothing after the flip-flops. The bench applies each input set just after a falling edge. It first samples `q_o` a short time later, while the clock is still low, to confirm that nothing has moved yet (R7). It then advances its behavioural model at the rising edge and compares at the next falling edge. All sixteen control combinations are applied under several data and serial-bit patterns, so that each priority level is seen winning over every lower one.

// File: rtl/prio_mfreg_pkg.sv
// Package: shared select encoding for the priority multifunction register.
// Assumes: a 3-bit select; codes 5..7 are unused and mean "keep".
package prio_mfreg_pkg;
    localparam int unsigned SEL_W = 3;

    typedef logic [SEL_W-1:0] sel_t;

    localparam sel_t SEL_KEEP  = 3'd0;
    localparam sel_t SEL_LOAD  = 3'd1;
    localparam sel_t SEL_SHIFT = 3'd2;
    localparam sel_t SEL_CLEAR = 3'd3;
    localparam sel_t SEL_SET   = 3'd4;
endpackage

// File: rtl/prio_mfreg_enc.sv
// Module: prio_mfreg_enc
// Resolves the four independent control lines into one select code.
// Fixed priority: clear > set > load > shift; none asserted gives keep.
// Assumes: purely combinational, used once per register.
module prio_mfreg_enc
    import prio_mfreg_pkg::*;
(
    input  logic clr,
    input  logic set,
    input  logic load,
    input  logic shift,
    output sel_t sel
);
    // Priority chain picking the winning operation.
    always_comb begin
        if (clr)        sel = SEL_CLEAR;
        else if (set)   sel = SEL_SET;
        else if (load)  sel = SEL_LOAD;
        else if (shift) sel = SEL_SHIFT;
        else            sel = SEL_KEEP;
    end
endmodule

// File: rtl/prio_mfreg_bitsel.sv
// Module: prio_mfreg_bitsel
// Eight-way next-value selector for a single register bit.
// Assumes: the caller supplies the bit's own value, its load bit and the
// value of its lower neighbour (or the serial input for bit 0).
module prio_mfreg_bitsel
    import prio_mfreg_pkg::*;
(
    input  sel_t sel,
    input  logic cur,
    input  logic load_bit,
    input  logic lower_bit,
    output logic nxt
);
    // Per-bit selection; unused codes fall back to keeping the bit.
    always_comb begin
        case (sel)
            SEL_KEEP:  nxt = cur;
            SEL_LOAD:  nxt = load_bit;
            SEL_SHIFT: nxt = lower_bit;
            SEL_CLEAR: nxt = 1'b0;
            SEL_SET:   nxt = 1'b1;
            3'd5:      nxt = cur;
            3'd6:      nxt = cur;
            default:   nxt = cur;
        endcase
    end
endmodule

// File: rtl/prio_mfreg.sv
// Module: prio_mfreg (top)
// N-bit register with clear, set, load and left shift, resolved by priority.
// Assumes: synchronous active-low reset to zero; outputs come straight from
// the flip-flops; W >= 1.
module prio_mfreg
    import prio_mfreg_pkg::*;
#(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         set_i,
    input  logic         load_i,
    input  logic         shift_i,
    input  logic         shift_in_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] q_o
);
    localparam int unsigned MSB = W - 1;

    sel_t         sel;
    logic [MSB:0] q_r;
    logic [MSB:0] nxt;
    logic [MSB:0] lower;

    prio_mfreg_enc u_enc (
        .clr   (clr_i),
        .set   (set_i),
        .load  (load_i),
        .shift (shift_i),
        .sel   (sel)
    );

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            assign lower[i] = shift_in_i;
        end else begin : g_upper
            assign lower[i] = q_r[i-1];
        end

        prio_mfreg_bitsel u_sel (
            .sel       (sel),
            .cur       (q_r[i]),
            .load_bit  (din_i[i]),
            .lower_bit (lower[i]),
            .nxt       (nxt[i])
        );
    end

    // State register: synchronous reset, otherwise take the selected value.
    always_ff @(posedge clk) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= nxt;
    end

    assign q_o = q_r;
endmodule

// File: rtl/prio_mfreg_chk.sv
// Module: prio_mfreg_chk
// Property checker for prio_mfreg, attached with bind below.
// Assumes: the same W as the register it watches.
module prio_mfreg_chk #(
    parameter int unsigned W = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         clr_i,
    input logic         set_i,
    input logic         load_i,
    input logic         shift_i,
    input logic         shift_in_i,
    input logic [W-1:0] din_i,
    input logic [W-1:0] q_o
);
    logic [W:0] shifted;
    assign shifted = {q_o, shift_in_i};

    // R1: a low reset at an edge forces zeros after it
    a_r1_sync_reset: assert property (@(posedge clk)
        !rst_n |=> q_o == '0);

    // R2: clear beats every other control
    a_r2_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> q_o == '0);

    // R3: set beats load and shift
    a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && set_i) |=> q_o == '1);

    // R4: load beats shift
    a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i && load_i) |=> q_o == $past(din_i));

    // R5: shift moves bits up and enters the serial bit at bit 0
    a_r5_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i && !load_i && shift_i) |=> q_o == $past(shifted[W-1:0]));

    // R6: no control keeps the value
    a_r6_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i && !load_i && !shift_i) |=> $stable(q_o));
endmodule

bind prio_mfreg prio_mfreg_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr_i),
    .set_i      (set_i),
    .load_i     (load_i),
    .shift_i    (shift_i),
    .shift_in_i (shift_in_i),
    .din_i      (din_i),
    .q_o        (q_o)
);

// File: tb/prio_mfreg_tb.sv
// Bench for prio_mfreg: behavioural reference model compared every cycle.
module prio_mfreg_tb;
    localparam int unsigned W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clr_i = 1'b0, set_i = 1'b0, load_i = 1'b0, shift_i = 1'b0;
    logic         shift_in_i = 1'b0;
    logic [W-1:0] din_i = '0;
    logic [W-1:0] q_o;

    logic [W-1:0] model = '0;
    int           checks = 0;
    int           errors = 0;

    always #5 clk = ~clk;

    prio_mfreg #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .set_i(set_i),
        .load_i(load_i), .shift_i(shift_i), .shift_in_i(shift_in_i),
        .din_i(din_i), .q_o(q_o)
    );

    // Single comparison with FAIL reporting.
    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: q_o=%b expected=%b", req, act, exp);
        end
    endtask

    // One cycle: drive after a falling edge, verify quiet output (R7),
    // advance the model at the rising edge, compare at the next falling edge.
    task automatic step(input logic rn, input logic [3:0] ctl, input logic sin,
                        input logic [W-1:0] d);
        string tag;
        rst_n = rn; clr_i = ctl[3]; set_i = ctl[2]; load_i = ctl[1]; shift_i = ctl[0];
        shift_in_i = sin; din_i = d;
        #2 check("R7", q_o, model);
        @(posedge clk);
        if (!rn)           begin model = '0;  tag = "R1"; end
        else if (ctl[3])   begin model = '0;  tag = "R2"; end
        else if (ctl[2])   begin model = '1;  tag = "R3"; end
        else if (ctl[1])   begin model = d;   tag = "R4"; end
        else if (ctl[0])   begin model = W'((int'(model) << 1) | int'(sin)); tag = "R5"; end
        else               tag = "R6";
        @(negedge clk);
        check(tag, q_o, model);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset with controls asserted still gives zero
        step(1'b0, 4'b0100, 1'b1, 4'hF);
        step(1'b0, 4'b0010, 1'b1, 4'hA);
        // Exhaustive control combinations under several data patterns
        for (int p = 0; p < 4; p++) begin
            for (int c = 0; c < 16; c++) begin
                step(1'b1, 4'b0010, 1'b0, W'(4'h5 + p * 3));       // seed a known value
                step(1'b1, c[3:0], p[0], W'(4'hA ^ (c + p)));
            end
        end
        // R5: long shift sequence with alternating serial bits, MSB falls off
        step(1'b1, 4'b0010, 1'b0, 4'b1001);
        for (int k = 0; k < 6; k++) step(1'b1, 4'b0001, k[0], 4'h0);
        // R6: data and serial input ignored while holding
        step(1'b1, 4'b0010, 1'b0, 4'b0110);
        for (int k = 0; k < 3; k++) step(1'b1, 4'b0000, 1'b1, W'(k * 5));
        // R1: reset in the middle of operation
        step(1'b0, 4'b0001, 1'b1, 4'hF);
        step(1'b1, 4'b0100, 1'b0, 4'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule